// File: doc/BRIEF.md
# Flash Command Register Sequencer

This block is the command front end of a serial flash controller for quad and octal memories. Software programs a small bank of 32-bit command words over a simple register interface. The words hold an opcode, up to six address bytes, lane widths, a bank select, a transfer length, dummy cycles and a direction. Command word 0 is written last, and that write launches the instruction. The block decodes the stored words into a parallel descriptor and hands it to a downstream serial sequencer with a one-cycle start pulse. It then holds a busy flag until the sequencer reports the end of the operation, and records the outcome in a status word.

There are two kinds of step. A command step sends an opcode and address. Its instruction type says whether a data transfer follows (type 1) or not (type 0). A data step (type 127) carries the byte count, dummy cycles and direction. A data step is accepted only directly after a successful type-1 command. The block rejects, and reports as an invalid sequence, any launch that is out of order, has an unknown type, or arrives while the work mode is not command mode.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, every command word, the mode register, the status word (offset 0x044) and the controller status (offset 0x100) read as zero, and no start pulse is issued.
- R2: Command words 0..5 at offsets 0x000..0x014 read back the last value written. The mode register at 0x230 keeps only bits 6:5 and reads zero elsewhere.
- R3: When mode is 1, writing word 0 with type 0 or 1 in word 1 bits 6:0 sets busy (offset 0x100 bit 7) and pulses start for one cycle, both on the next clock edge. The status word clears, and the descriptor carries the following fields: opcode = word 3 bits 23:16; address = {word 3[7:0], word 2, word 1[31:24]}; address byte count = word 3 bits 30:28; address lanes = word 4 bits 1:0; command lanes = word 4 bits 9:8; bank = word 4 bits 14:12.
- R4: Busy falls one cycle after the sequencer signals done. Status then reads bit 15 = 1 and bit 14 = OR of the error inputs. Bits 3, 2 and 1 are the error input bits 2, 1 and 0 (pulse-strobe error, CRC error, bus error).
- R5: A type-127 launch directly after a type-1 command that completed without error starts a data step with a 32-bit count = {word 3[15:0], word 2[31:16]}, dummy = word 3 bits 25:20 and write = word 4 bit 4 (0 read, 1 write).
- R6: A type-127 launch with no pending successful type-1 command is rejected. Status reads 0xC001 on the next edge, and busy and start stay low.
- R7: A launch while the mode field is not 1 is rejected with status 0xC001 and no busy or start.
- R8: A write to word 0 while busy has no effect on busy, start or status.
- R9: When a data step finishes, the done output pulses for one cycle if bit 0 of word 0 was set at its launch, and stays low otherwise.
- R10: A launch with any type other than 0, 1 or 127 is rejected with status 0xC001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 12 | Register read byte offset |
| rd_data | output | 32 | Register read data (combinational) |
| seq_start_o | output | 1 | One-cycle start to the sequencer |
| seq_data_o | output | 1 | 1 for a data step, 0 for a command step |
| seq_opcode_o | output | 8 | Opcode |
| seq_addr_o | output | 48 | Address, byte 0 in bits 7:0 |
| seq_addr_bytes_o | output | 3 | Number of address bytes |
| seq_addr_lanes_o | output | 2 | log2 of address lanes |
| seq_cmd_lanes_o | output | 2 | log2 of command lanes |
| seq_bank_o | output | 3 | Bank select |
| seq_count_o | output | 32 | Data byte count |
| seq_dummy_o | output | 6 | Dummy cycles |
| seq_write_o | output | 1 | Data direction, 1 = write |
| seq_done_i | input | 1 | Sequencer finished the step |
| seq_err_i | input | 3 | Errors with done: {strobe, crc, bus} |
| done_o | output | 1 | Notification pulse at the end of a data step |

## Verification
The in-RTL properties check the handshake timing on every cycle. Start is a single pulse that coincides with busy rising. Busy drops on the edge after done, and a completed step always leaves the completion bit set. A notification never appears without a step having been busy. They cannot show that the descriptor fields land in the right bits, that the ordering rule between type-1 and type-127 steps holds, or that the rejection codes are right. Those are shown by the bench sweeps over modes, instruction types, error codes, banks, lane widths and data counts.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
    localparam int ADDR_W    = 12;
    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 6;
    localparam int STAT_W    = 16;

    localparam logic [ADDR_W-1:0] OFF_WORD0  = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_STATUS = 12'h044;
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 12'h100;
    localparam logic [ADDR_W-1:0] OFF_MODE   = 12'h230;

    localparam logic [6:0] TYPE_CMD      = 7'd0;
    localparam logic [6:0] TYPE_CMD_DATA = 7'd1;
    localparam logic [6:0] TYPE_DATA     = 7'd127;

    localparam logic [1:0] MODE_CMD = 2'd1;

    localparam logic [STAT_W-1:0] STAT_REJECT = 16'hC001;

    typedef struct packed {
        logic [6:0]  itype;
        logic [7:0]  opcode;
        logic [47:0] addr;
        logic [2:0]  addr_bytes;
        logic [1:0]  addr_lanes;
        logic [1:0]  cmd_lanes;
        logic [2:0]  bank;
        logic [31:0] count;
        logic [5:0]  dummy;
        logic        write;
    } cmd_desc_t;
endpackage

// File: rtl/flash_cmd_regfile.sv
module flash_cmd_regfile
    import flash_cmd_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [WORD_W-1:0]                 wr_data,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]  words_q,
    output logic [1:0]                        mode_q
);
    logic [NUM_WORDS-1:0][WORD_W-1:0] words_d;
    logic [1:0]                       mode_d;

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        localparam logic [ADDR_W-1:0] OFF = OFF_WORD0 + ADDR_W'(4 * i);
        always_comb begin
            words_d[i] = words_q[i];
            if (wr_en && wr_addr == OFF) words_d[i] = wr_data;
        end
    end

    always_comb begin
        mode_d = mode_q;
        if (wr_en && wr_addr == OFF_MODE) mode_d = wr_data[6:5];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            words_q <= '0;
            mode_q  <= '0;
        end else begin
            words_q <= words_d;
            mode_q  <= mode_d;
        end
    end
endmodule

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_cmd_pkg::*;
(
    input  logic [WORD_W-1:0] w1,
    input  logic [WORD_W-1:0] w2,
    input  logic [WORD_W-1:0] w3,
    input  logic [WORD_W-1:0] w4,
    output cmd_desc_t         desc
);
    always_comb begin
        desc            = '0;
        desc.itype      = w1[6:0];
        desc.addr       = {w3[7:0], w2, w1[31:24]};
        desc.opcode     = w3[23:16];
        desc.addr_bytes = w3[30:28];
        desc.addr_lanes = w4[1:0];
        desc.cmd_lanes  = w4[9:8];
        desc.bank       = w4[14:12];
        desc.count      = {w3[15:0], w2[31:16]};
        desc.dummy      = w3[25:20];
        desc.write      = w4[4];
    end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [11:0]       wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [11:0]       rd_addr,
    output logic [31:0]       rd_data,
    output logic              seq_start_o,
    output logic              seq_data_o,
    output logic [7:0]        seq_opcode_o,
    output logic [47:0]       seq_addr_o,
    output logic [2:0]        seq_addr_bytes_o,
    output logic [1:0]        seq_addr_lanes_o,
    output logic [1:0]        seq_cmd_lanes_o,
    output logic [2:0]        seq_bank_o,
    output logic [31:0]       seq_count_o,
    output logic [5:0]        seq_dummy_o,
    output logic              seq_write_o,
    input  logic              seq_done_i,
    input  logic [2:0]        seq_err_i,
    output logic              done_o
);
    typedef struct packed {
        logic              busy;
        logic              start;
        logic              pending;
        logic              notify;
        logic              is_data;
        logic              is_cd;
        logic              done;
        logic [STAT_W-1:0] status;
        cmd_desc_t         desc;
    } ctl_t;

    logic [NUM_WORDS-1:0][WORD_W-1:0] words_q;
    logic [1:0]                       mode_q;
    cmd_desc_t                        dec;
    ctl_t                             ctl_d, ctl_q;
    logic                             launch;

    flash_cmd_regfile i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .words_q (words_q),
        .mode_q  (mode_q)
    );

    flash_cmd_decode i_dec (
        .w1   (words_q[1]),
        .w2   (words_q[2]),
        .w3   (words_q[3]),
        .w4   (words_q[4]),
        .desc (dec)
    );

    assign launch = wr_en && (wr_addr == OFF_WORD0) && !ctl_q.busy;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.start = 1'b0;
        ctl_d.done  = 1'b0;
        if (ctl_q.busy && seq_done_i) begin
            ctl_d.busy   = 1'b0;
            ctl_d.status = {1'b1, |seq_err_i, 10'b0, seq_err_i, 1'b0};
            ctl_d.pending = ctl_q.is_cd && !(|seq_err_i);
            ctl_d.done   = ctl_q.is_data && ctl_q.notify;
        end else if (launch) begin
            ctl_d.pending = 1'b0;
            ctl_d.status  = STAT_REJECT;
            if (mode_q == MODE_CMD &&
                (dec.itype == TYPE_CMD || dec.itype == TYPE_CMD_DATA ||
                 (dec.itype == TYPE_DATA && ctl_q.pending))) begin
                ctl_d.busy    = 1'b1;
                ctl_d.start   = 1'b1;
                ctl_d.status  = '0;
                ctl_d.desc    = dec;
                ctl_d.notify  = wr_data[0];
                ctl_d.is_data = (dec.itype == TYPE_DATA);
                ctl_d.is_cd   = (dec.itype == TYPE_CMD_DATA);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr < OFF_WORD0 + 12'(4 * NUM_WORDS) && rd_addr[1:0] == 2'b00)
            rd_data = words_q[rd_addr[4:2]];
        else if (rd_addr == OFF_STATUS) rd_data = 32'(ctl_q.status);
        else if (rd_addr == OFF_CTRL)   rd_data = {24'b0, ctl_q.busy, 7'b0};
        else if (rd_addr == OFF_MODE)   rd_data = {25'b0, mode_q, 5'b0};
    end

    assign seq_start_o      = ctl_q.start;
    assign seq_data_o       = ctl_q.is_data;
    assign seq_opcode_o     = ctl_q.desc.opcode;
    assign seq_addr_o       = ctl_q.desc.addr;
    assign seq_addr_bytes_o = ctl_q.desc.addr_bytes;
    assign seq_addr_lanes_o = ctl_q.desc.addr_lanes;
    assign seq_cmd_lanes_o  = ctl_q.desc.cmd_lanes;
    assign seq_bank_o       = ctl_q.desc.bank;
    assign seq_count_o      = ctl_q.desc.count;
    assign seq_dummy_o      = ctl_q.desc.dummy;
    assign seq_write_o      = ctl_q.desc.write;
    assign done_o           = ctl_q.done;

    AST_START_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start_o |-> ctl_q.busy); // R3
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start_o |=> !seq_start_o); // R3
    AST_BUSY_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.busy && seq_done_i) |=> (!ctl_q.busy && ctl_q.status[15])); // R4
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.busy && !seq_done_i) |=> !seq_start_o); // R8
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(ctl_q.busy) && !ctl_q.busy)); // R9
endmodule

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        seq_start_o, seq_data_o, seq_write_o, done_o;
    logic [7:0]  seq_opcode_o;
    logic [47:0] seq_addr_o;
    logic [2:0]  seq_addr_bytes_o, seq_bank_o;
    logic [1:0]  seq_addr_lanes_o, seq_cmd_lanes_o;
    logic [31:0] seq_count_o;
    logic [5:0]  seq_dummy_o;
    logic        seq_done_i = 1'b0;
    logic [2:0]  seq_err_i = '0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    flash_cmd_seq i_flash_cmd_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .seq_start_o(seq_start_o), .seq_data_o(seq_data_o),
        .seq_opcode_o(seq_opcode_o), .seq_addr_o(seq_addr_o),
        .seq_addr_bytes_o(seq_addr_bytes_o), .seq_addr_lanes_o(seq_addr_lanes_o),
        .seq_cmd_lanes_o(seq_cmd_lanes_o), .seq_bank_o(seq_bank_o),
        .seq_count_o(seq_count_o), .seq_dummy_o(seq_dummy_o),
        .seq_write_o(seq_write_o), .seq_done_i(seq_done_i),
        .seq_err_i(seq_err_i), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic finish_seq(input logic [2:0] e);
        seq_err_i = e; seq_done_i = 1'b1;
        @(negedge clk);
        seq_done_i = 1'b0; seq_err_i = '0;
    endtask

    task automatic expect_reject(input string req);
        logic [31:0] v;
        chk(!seq_start_o, req, seq_start_o, 0);
        rd(12'h100, v); chk(v == 0, req, v, 0);
        rd(12'h044, v); chk(v == 32'hC001, req, v, 32'hC001);
    endtask

    // program command words 1..4 for a command step
    task automatic load_cmd(input logic [6:0] ty, input logic [47:0] a,
                            input logic [7:0] op, input logic [2:0] nb,
                            input logic [1:0] al, input logic [1:0] cl,
                            input logic [2:0] bk);
        wr(12'h004, {a[7:0], 17'b0, ty});
        wr(12'h008, a[39:8]);
        wr(12'h00C, {1'b0, nb, 4'b0, op, 8'b0, a[47:40]});
        wr(12'h010, {17'b0, bk, 2'b0, cl, 6'b0, al});
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [47:0] a;
        logic [31:0] cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < 6; i++) begin
            rd(12'(4 * i), v); chk(v == 0, "R1 word", v, 0);
        end
        rd(12'h044, v); chk(v == 0, "R1 status", v, 0);
        rd(12'h100, v); chk(v == 0, "R1 busy", v, 0);
        rd(12'h230, v); chk(v == 0, "R1 mode", v, 0);
        chk(!seq_start_o, "R1 start", seq_start_o, 0);

        // R2 readback; words 1..5 first so no launch with mode 0 matters
        for (int i = 5; i >= 1; i--) begin
            wr(12'(4 * i), 32'h1357_9BDF * (i + 1));
            rd(12'(4 * i), v);
            chk(v == 32'h1357_9BDF * (i + 1), "R2 word", v, 32'h1357_9BDF * (i + 1));
        end
        wr(12'h230, 32'hFFFF_FFFF);
        rd(12'h230, v); chk(v == 32'h60, "R2 mode mask", v, 32'h60);

        // R7 mode sweep with a type-0 command
        load_cmd(7'd0, 48'h0, 8'h05, 3'd0, 2'd0, 2'd0, 3'd0);
        for (int m = 0; m < 4; m++) begin
            if (m == 1) continue;
            wr(12'h230, 32'(m) << 5);
            wr(12'h000, 32'h0);
            expect_reject("R7");
        end
        wr(12'h230, 32'h20);

        // R3, R4 command sweep over bank, lanes, byte count and error code
        for (int k = 0; k < 8; k++) begin
            a = 48'h1122_3344_5566 ^ (48'h0F0F_0F0F_0F0F * k);
            load_cmd(7'(k % 2), a, 8'(k * 29 + 3), 3'(k), 2'(k), 2'(3 - k % 4), 3'(k));
            wr(12'h000, 32'h0);
            chk(seq_start_o, "R3 start", seq_start_o, 1);
            chk(!seq_data_o, "R3 kind", seq_data_o, 0);
            chk(seq_addr_o == a, "R3 addr", seq_addr_o, a);
            chk(seq_opcode_o == 8'(k * 29 + 3), "R3 opcode", seq_opcode_o, 8'(k * 29 + 3));
            chk(seq_addr_bytes_o == 3'(k) && seq_bank_o == 3'(k), "R3 bytes/bank",
                {seq_addr_bytes_o, seq_bank_o}, {3'(k), 3'(k)});
            chk(seq_addr_lanes_o == 2'(k) && seq_cmd_lanes_o == 2'(3 - k % 4), "R3 lanes",
                {seq_addr_lanes_o, seq_cmd_lanes_o}, {2'(k), 2'(3 - k % 4)});
            rd(12'h100, v); chk(v == 32'h80, "R3 busy", v, 32'h80);
            rd(12'h044, v); chk(v == 0, "R3 status clear", v, 0);
            @(negedge clk);
            chk(!seq_start_o, "R3 pulse", seq_start_o, 0);
            // R8: relaunch while busy is ignored
            wr(12'h000, 32'h1);
            chk(!seq_start_o, "R8 start", seq_start_o, 0);
            rd(12'h100, v); chk(v == 32'h80, "R8 busy", v, 32'h80);
            rd(12'h044, v); chk(v == 0, "R8 status", v, 0);
            finish_seq(3'(k));
            rd(12'h100, v); chk(v == 0, "R4 busy fall", v, 0);
            rd(12'h044, v);
            chk(v == (32'h8000 | (k != 0 ? 32'h4000 : 0) | (32'(k) << 1)), "R4 status",
                v, 32'h8000 | (k != 0 ? 32'h4000 : 0) | (32'(k) << 1));
            // R6: data step after a type-0 or after a failed type-1 is rejected
            if (k % 2 == 0 || k != 0) begin
                wr(12'h004, 32'd127);
                wr(12'h000, 32'h1);
                expect_reject("R6");
            end
        end

        // R5, R9 data steps after successful type-1 commands
        for (int j = 0; j < 4; j++) begin
            load_cmd(7'd1, 48'hA5, 8'h0B, 3'd3, 2'd0, 2'd0, 3'(j + 2));
            wr(12'h000, 32'h0);
            finish_seq(3'd0);
            cnt = 32'h0001_0000 * (j * 7 + 1) + 32'(j * 1000 + 5);
            wr(12'h004, 32'd127);
            wr(12'h008, {cnt[15:0], 16'h0});
            wr(12'h00C, {6'b0, 6'(j * 9 + 1), 4'b0, cnt[31:16]});
            wr(12'h010, {17'b0, 3'(j + 2), 7'b0, 1'(j >> 1), 4'b0});
            wr(12'h000, 32'(j & 1));
            chk(seq_start_o && seq_data_o, "R5 start", {seq_start_o, seq_data_o}, 2'b11);
            chk(seq_count_o == cnt, "R5 count", seq_count_o, cnt);
            chk(seq_dummy_o == 6'(j * 9 + 1), "R5 dummy", seq_dummy_o, 6'(j * 9 + 1));
            chk(seq_write_o == 1'(j >> 1), "R5 dir", seq_write_o, 1'(j >> 1));
            chk(seq_bank_o == 3'(j + 2), "R5 bank", seq_bank_o, 3'(j + 2));
            repeat (2) @(negedge clk);
            chk(!done_o, "R9 early", done_o, 0);
            finish_seq(3'd0);
            chk(done_o == 1'(j & 1), "R9 notify", done_o, 1'(j & 1));
            @(negedge clk);
            chk(!done_o, "R9 pulse", done_o, 0);
            // pending consumed: second data step rejected (R6)
            wr(12'h000, 32'h0);
            expect_reject("R6 consumed");
        end

        // R10 unknown instruction types
        for (int t = 2; t < 127; t += 31) begin
            wr(12'h004, 32'(t));
            wr(12'h000, 32'h0);
            expect_reject("R10");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule